// File: doc/BRIEF.md
# Passive-Matrix LCD Timing Generator

This block derives the control waveforms for a passive-matrix (STN) LCD column/row driver from the master clock. From a set of static configuration fields it produces a gated pixel clock, a line latch pulse, a frame start pulse and an AC polarity signal. It also produces a one-cycle data-shift enable, so that a separate pixel formatter can update the data bus at each rising pixel-clock edge. The driver then samples the bus on the falling edge.

Each line has a fixed sequence of phases:
- a shift phase of `hozCount+1` pixel clocks;
- a line pulse that lasts `pulseWidth` master cycles;
- a quiet delay of `postDelay` master cycles;
- a blanking gap of `lineBlank` master cycles.

A frame holds `lineCount+1` such lines. The polarity signal toggles either once per frame or after a programmable number of line pulses. The scan-mode field selects which data lanes the formatter drives, and the unused encoding parks the block.

Configuration is expected to be stable while `enable` is high. Lowering `enable` clears every counter and forces the outputs low.

Top module: `stn_timing_gen`

## Requirements
- R1: While active, `pixClk` has a period of 2·C master cycles, where C = `clkDiv`, or 2 when `clkDiv` < 2. In each period it is low for the first C cycles and high for the last C cycles. `pixClk` is low outside the shift phase.
- R2: `shiftEn` is high for exactly the one master cycle before each rising edge of `pixClk`, and at no other time.
- R3: Each line opens with `hozCount+1` pixel-clock periods. These are followed by `linePulse` held high for max(`pulseWidth`,1) consecutive cycles, and `pixClk` is low during the pulse.
- R4: After the line pulse, `postDelay` cycles and then `lineBlank` cycles follow with `pixClk`, `shiftEn` and `linePulse` all low. A zero value skips that phase. The next line then begins, so a line lasts 2·C·(`hozCount`+1) + max(`pulseWidth`,1) + `postDelay` + `lineBlank` cycles.
- R5: Lines are numbered from 0 after activation. `framePulse` is high exactly during the line pulse of line `lineCount`, after which numbering restarts at 0.
- R6: With `vmLineMode` = 0, `acPolarity` starts low and inverts in the first cycle after the line pulse of each frame's last line.
- R7: With `vmLineMode` = 1, `acPolarity` starts low and inverts in the first cycle after every M-th line pulse, where M = max(`vmCount`,1). The rate of `acPolarity` is therefore the line rate divided by 2·M.
- R8: `dataLanes` (bit 0 = low nibble, bit 1 = high nibble) reads 2'b11 for `scanMode` 2'b00 (4-bit dual scan), 2'b01 for 2'b01 (4-bit single scan) and 2'b11 for 2'b10 (8-bit single scan). For 2'b11 (unused), `dataLanes` reads 2'b00, all timing outputs stay low and the counters are held cleared.
- R9: While `enable` is low, all outputs are low and all counters are cleared. Raising `enable` restarts at line 0, at the start of the shift phase, with `acPolarity` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low clears counters and outputs |
| clkDiv | input | DIV_W | Pixel clock half-period in master cycles (min 2) |
| hozCount | input | HCNT_W | Pixel clocks per line minus 1 |
| lineCount | input | LCNT_W | Lines per frame minus 1 |
| pulseWidth | input | TIME_W | Line pulse width in master cycles (min 1) |
| postDelay | input | TIME_W | Delay after the line pulse in master cycles |
| lineBlank | input | TIME_W | Blank gap before the next line in master cycles |
| vmLineMode | input | 1 | 0: polarity per frame, 1: per vmCount line pulses |
| vmCount | input | MV_W | Line pulses per polarity half-period (min 1) |
| scanMode | input | 2 | 00 dual 4-bit, 01 single 4-bit, 10 single 8-bit, 11 unused |
| pixClk | output | 1 | Gated pixel clock |
| shiftEn | output | 1 | Data update strobe ahead of each pixel clock rise |
| linePulse | output | 1 | Line latch pulse |
| framePulse | output | 1 | Frame start pulse |
| acPolarity | output | 1 | LCD AC drive polarity |
| dataLanes | output | 2 | Active data nibbles for the formatter |

## Verification
The hardest situation to reach is the one where every zero-length and minimum-clamped field meets at once. That means `clkDiv` below 2, a zero pulse width, zero delay and blank gaps, and a single-line frame, so that the phase sequencer must skip straight from the line pulse back to shifting while the polarity and frame logic act on every line. Directed runs set those fields together. Seeded random configurations with small counts then sweep the remaining combinations of both polarity modes over several frames. Each master cycle is compared against a closed-form model of position within the line and frame. Enable drops between runs confirm that each restart begins fresh.

// File: rtl/stn_timing_pkg.sv
package stn_timing_pkg;
  typedef enum logic [1:0] {PH_SHIFT, PH_PULSE, PH_DELAY, PH_BLANK} phase_e;
  typedef enum logic [1:0] {LD_NONE, LD_PULSE, LD_DELAY, LD_BLANK} load_e;

  typedef struct packed {
    logic   clear;
    phase_e phase;
    load_e  load;
    logic   lineDone;
  } strobe_t;
endpackage

// File: rtl/stn_timing_ctrl.sv
module stn_timing_ctrl
  import stn_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] scanMode,
  input  logic       pixLast,
  input  logic       phLast,
  input  logic       delayZero,
  input  logic       blankZero,
  output strobe_t    strobe
);
  phase_e state, stateNext;
  load_e  loadSel;
  logic   active, lineDone;

  assign active = enable && (scanMode != 2'b11);

  always_comb begin
    stateNext = state;
    loadSel   = LD_NONE;
    lineDone  = 1'b0;
    case (state)
      PH_SHIFT: if (pixLast) begin
        stateNext = PH_PULSE;
        loadSel   = LD_PULSE;
      end
      PH_PULSE: if (phLast) begin
        lineDone = 1'b1;
        if (!delayZero) begin
          stateNext = PH_DELAY;
          loadSel   = LD_DELAY;
        end else if (!blankZero) begin
          stateNext = PH_BLANK;
          loadSel   = LD_BLANK;
        end else begin
          stateNext = PH_SHIFT;
        end
      end
      PH_DELAY: if (phLast) begin
        if (!blankZero) begin
          stateNext = PH_BLANK;
          loadSel   = LD_BLANK;
        end else begin
          stateNext = PH_SHIFT;
        end
      end
      default: if (phLast) stateNext = PH_SHIFT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) state <= PH_SHIFT;
    else                  state <= stateNext;
  end

  assign strobe.clear    = !rstN || !active;
  assign strobe.phase    = state;
  assign strobe.load     = active ? loadSel : LD_NONE;
  assign strobe.lineDone = active && lineDone;
endmodule

// File: rtl/stn_timing_dp.sv
module stn_timing_dp
  import stn_timing_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HCNT_W = 10,
  parameter int LCNT_W = 10,
  parameter int TIME_W = 8,
  parameter int MV_W   = 8
) (
  input  logic              clk,
  input  strobe_t           strobe,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [HCNT_W-1:0] hozCount,
  input  logic [LCNT_W-1:0] lineCount,
  input  logic [TIME_W-1:0] pulseWidth,
  input  logic [TIME_W-1:0] postDelay,
  input  logic [TIME_W-1:0] lineBlank,
  input  logic              vmLineMode,
  input  logic [MV_W-1:0]   vmCount,
  output logic              pixLast,
  output logic              phLast,
  output logic              delayZero,
  output logic              blankZero,
  output logic              pixClk,
  output logic              shiftEn,
  output logic              linePulse,
  output logic              framePulse,
  output logic              acPolarity
);
  localparam int DCW = DIV_W + 1;

  logic [DCW-1:0]    divCnt, halfC, fullM1;
  logic [HCNT_W-1:0] hCnt;
  logic [TIME_W-1:0] phCnt, effW;
  logic [LCNT_W-1:0] lCnt;
  logic [MV_W-1:0]   vmCnt, effM;
  logic              vmReg, divLast, lastLine, inShift;

  assign halfC    = (clkDiv < DIV_W'(2)) ? DCW'(2) : {1'b0, clkDiv};
  assign fullM1   = (halfC << 1) - DCW'(1);
  assign effW     = (pulseWidth == '0) ? TIME_W'(1) : pulseWidth;
  assign effM     = (vmCount == '0) ? MV_W'(1) : vmCount;
  assign inShift  = (strobe.phase == PH_SHIFT);
  assign divLast  = (divCnt == fullM1);
  assign pixLast  = inShift && divLast && (hCnt == hozCount);
  assign phLast   = (phCnt == TIME_W'(1));
  assign lastLine = (lCnt == lineCount);
  assign delayZero = (postDelay == '0);
  assign blankZero = (lineBlank == '0);

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      divCnt <= '0;
      hCnt   <= '0;
      phCnt  <= '0;
      lCnt   <= '0;
      vmCnt  <= '0;
      vmReg  <= 1'b0;
    end else begin
      if (inShift) begin
        if (divLast) begin
          divCnt <= '0;
          hCnt   <= pixLast ? '0 : hCnt + HCNT_W'(1);
        end else begin
          divCnt <= divCnt + DCW'(1);
        end
      end
      case (strobe.load)
        LD_PULSE: phCnt <= effW;
        LD_DELAY: phCnt <= postDelay;
        LD_BLANK: phCnt <= lineBlank;
        default:  if (phCnt != '0) phCnt <= phCnt - TIME_W'(1);
      endcase
      if (strobe.lineDone) begin
        lCnt <= lastLine ? '0 : lCnt + LCNT_W'(1);
        if (vmLineMode) begin
          if (vmCnt + MV_W'(1) >= effM) begin
            vmCnt <= '0;
            vmReg <= !vmReg;
          end else begin
            vmCnt <= vmCnt + MV_W'(1);
          end
        end else if (lastLine) begin
          vmReg <= !vmReg;
        end
      end
    end
  end

  assign pixClk     = !strobe.clear && inShift && (divCnt >= halfC);
  assign shiftEn    = !strobe.clear && inShift && (divCnt == halfC - DCW'(1));
  assign linePulse  = !strobe.clear && (strobe.phase == PH_PULSE);
  assign framePulse = linePulse && lastLine;
  assign acPolarity = !strobe.clear && vmReg;
endmodule

// File: rtl/stn_timing_gen.sv
module stn_timing_gen
  import stn_timing_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HCNT_W = 10,
  parameter int LCNT_W = 10,
  parameter int TIME_W = 8,
  parameter int MV_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [HCNT_W-1:0] hozCount,
  input  logic [LCNT_W-1:0] lineCount,
  input  logic [TIME_W-1:0] pulseWidth,
  input  logic [TIME_W-1:0] postDelay,
  input  logic [TIME_W-1:0] lineBlank,
  input  logic              vmLineMode,
  input  logic [MV_W-1:0]   vmCount,
  input  logic [1:0]        scanMode,
  output logic              pixClk,
  output logic              shiftEn,
  output logic              linePulse,
  output logic              framePulse,
  output logic              acPolarity,
  output logic [1:0]        dataLanes
);
  strobe_t strobe;
  logic    pixLast, phLast, delayZero, blankZero;

  stn_timing_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .scanMode(scanMode),
    .pixLast(pixLast), .phLast(phLast), .delayZero(delayZero),
    .blankZero(blankZero), .strobe(strobe)
  );

  stn_timing_dp #(
    .DIV_W(DIV_W), .HCNT_W(HCNT_W), .LCNT_W(LCNT_W),
    .TIME_W(TIME_W), .MV_W(MV_W)
  ) u_dp (
    .clk(clk), .strobe(strobe), .clkDiv(clkDiv), .hozCount(hozCount),
    .lineCount(lineCount), .pulseWidth(pulseWidth), .postDelay(postDelay),
    .lineBlank(lineBlank), .vmLineMode(vmLineMode), .vmCount(vmCount),
    .pixLast(pixLast), .phLast(phLast), .delayZero(delayZero),
    .blankZero(blankZero), .pixClk(pixClk), .shiftEn(shiftEn),
    .linePulse(linePulse), .framePulse(framePulse), .acPolarity(acPolarity)
  );

  always_comb begin
    if (!enable) dataLanes = 2'b00;
    else begin
      case (scanMode)
        2'b01:   dataLanes = 2'b01;
        2'b11:   dataLanes = 2'b00;
        default: dataLanes = 2'b11;
      endcase
    end
  end
endmodule

// File: rtl/stn_timing_chk.sv
module stn_timing_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [1:0] scanMode,
  input logic       pixClk,
  input logic       shiftEn,
  input logic       linePulse,
  input logic       framePulse,
  input logic       acPolarity,
  input logic [1:0] dataLanes
);
  AST_PULSE_NO_CLK: assert property (@(posedge clk) disable iff (!rstN)
    linePulse |-> !pixClk && !shiftEn); // R3

  AST_SHIFT_LEADS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !pixClk) |=> (pixClk || !enable || scanMode == 2'b11)); // R2

  AST_FRAME_IN_LINE: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |-> linePulse); // R5

  AST_VM_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && scanMode != 2'b11 && $past(scanMode) != 2'b11
     && !$stable(acPolarity)) |-> $fell(linePulse)); // R7

  AST_PARK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (enable && scanMode == 2'b11) |-> !pixClk && !linePulse && !framePulse
      && !acPolarity && dataLanes == 2'b00); // R8

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !pixClk && !shiftEn && !linePulse && !framePulse
      && !acPolarity && dataLanes == 2'b00); // R9
endmodule

bind stn_timing_gen stn_timing_chk u_chk (.*);

// File: tb/stn_timing_gen_tb.sv
module stn_timing_gen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] clkDiv = 8'd2;
  logic [9:0] hozCount = '0;
  logic [9:0] lineCount = '0;
  logic [7:0] pulseWidth = 8'd1;
  logic [7:0] postDelay = '0;
  logic [7:0] lineBlank = '0;
  logic       vmLineMode = 1'b0;
  logic [7:0] vmCount = 8'd1;
  logic [1:0] scanMode = 2'b01;
  logic       pixClk, shiftEn, linePulse, framePulse, acPolarity;
  logic [1:0] dataLanes;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = !clk;

  stn_timing_gen u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .clkDiv(clkDiv),
    .hozCount(hozCount), .lineCount(lineCount), .pulseWidth(pulseWidth),
    .postDelay(postDelay), .lineBlank(lineBlank), .vmLineMode(vmLineMode),
    .vmCount(vmCount), .scanMode(scanMode), .pixClk(pixClk),
    .shiftEn(shiftEn), .linePulse(linePulse), .framePulse(framePulse),
    .acPolarity(acPolarity), .dataLanes(dataLanes)
  );

  task automatic check(input string req, input int act, input int exp, input int t);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, exp);
    end
  endtask

  function automatic int lanesFor(input int sm);
    case (sm)
      1: return 1;
      3: return 0;
      default: return 3;
    endcase
  endfunction

  // expected outputs at cycle t after activation: {pix,shift,line,frame,vm}
  function automatic int expAt(input int t, input int c, input int h, input int l,
                               input int w, input int d, input int b,
                               input int mode, input int m);
    int ec, ew, em, s, p, pos, line, pulses, q;
    int pix, sh, lp, fp, vm;
    ec = (c < 2) ? 2 : c;
    ew = (w < 1) ? 1 : w;
    em = (m < 1) ? 1 : m;
    s = 2 * ec * (h + 1);
    p = s + ew + d + b;
    pos = t % p;
    line = (t / p) % (l + 1);
    pix = 0; sh = 0; lp = 0; fp = 0;
    if (pos < s) begin
      q = pos % (2 * ec);
      pix = (q >= ec) ? 1 : 0;
      sh = (q == ec - 1) ? 1 : 0;
    end else begin
      lp = (pos - s < ew) ? 1 : 0;
      fp = (lp != 0 && line == l) ? 1 : 0;
    end
    pulses = t / p + ((pos >= s + ew) ? 1 : 0);
    if (mode != 0) vm = (pulses / em) % 2;
    else           vm = (pulses / (l + 1)) % 2;
    return (pix << 4) | (sh << 3) | (lp << 2) | (fp << 1) | vm;
  endfunction

  task automatic run(input int c, input int h, input int l, input int w,
                     input int d, input int b, input int mode, input int m,
                     input int sm, input int cycles);
    int e;
    @(negedge clk);
    enable = 1'b0;
    clkDiv = 8'(c); hozCount = 10'(h); lineCount = 10'(l);
    pulseWidth = 8'(w); postDelay = 8'(d); lineBlank = 8'(b);
    vmLineMode = mode[0]; vmCount = 8'(m); scanMode = 2'(sm);
    for (int i = 0; i < 2; i++) begin
      #1;
      check("R9 idle outputs", {pixClk, shiftEn, linePulse, framePulse, acPolarity, dataLanes}, 0, -1);
      @(negedge clk);
    end
    enable = 1'b1;
    for (int t = 0; t < cycles; t++) begin
      #1;
      e = (sm == 3) ? 0 : expAt(t, c, h, l, w, d, b, mode, m);
      check("R8 dataLanes", int'(dataLanes), lanesFor(sm), t);
      check("R1 pixClk", int'(pixClk), (e >> 4) & 1, t);
      check("R2 shiftEn", int'(shiftEn), (e >> 3) & 1, t);
      check("R3/R4 linePulse", int'(linePulse), (e >> 2) & 1, t);
      check("R5 framePulse", int'(framePulse), (e >> 1) & 1, t);
      check(mode != 0 ? "R7 acPolarity" : "R6 acPolarity", int'(acPolarity), e & 1, t);
      @(negedge clk);
    end
  endtask

  function automatic int frameLen(input int c, input int h, input int l,
                                  input int w, input int d, input int b);
    int ec, ew;
    ec = (c < 2) ? 2 : c;
    ew = (w < 1) ? 1 : w;
    return (2 * ec * (h + 1) + ew + d + b) * (l + 1);
  endfunction

  initial begin
    int c, h, l, w, d, b, mode, m, sm;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 divider clamp with zero-length phases and single-line frame
    run(0, 2, 0, 0, 0, 0, 0, 1, 1, 120);
    run(1, 1, 0, 0, 0, 0, 1, 0, 0, 100);
    // R4 both gaps present, long pulse, R6 frame toggling
    run(3, 3, 2, 4, 3, 2, 0, 1, 2, 400);
    // R7 line mode every pulse and every 3 pulses
    run(2, 0, 3, 1, 1, 0, 1, 1, 1, 200);
    run(2, 2, 4, 2, 0, 3, 1, 3, 0, 500);
    // R8 unused scan mode parks outputs
    run(2, 2, 1, 1, 1, 1, 1, 1, 3, 60);
    // R9 restart after a run left polarity high
    run(2, 1, 0, 1, 0, 0, 0, 1, 1, 30);
    run(2, 1, 0, 1, 0, 0, 0, 1, 1, 60);
    for (int k = 0; k < 16; k++) begin
      c = $urandom_range(0, 4); h = $urandom_range(0, 6);
      l = $urandom_range(0, 3); w = $urandom_range(0, 4);
      d = $urandom_range(0, 3); b = $urandom_range(0, 3);
      mode = $urandom_range(0, 1); m = $urandom_range(0, 5);
      sm = $urandom_range(0, 2);
      run(c, h, l, w, d, b, mode, m, sm, 2 * frameLen(c, h, l, w, d, b) + 15);
    end
    @(negedge clk);
    enable = 1'b0;
    #1;
    check("R9 disable", {pixClk, linePulse, acPolarity, dataLanes}, 0, -1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #1500000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule